// File: doc/BRIEF.md
# In-Band Interrupt Payload Sequencer (I3C Target)

This block runs the target side of an In-Band Interrupt once the request bit is set. It asks the bus engine to put the interrupt header on the bus and waits for the controller to acknowledge or refuse it. After an acknowledge it sends the data phase over a byte stream toward the bus engine. The first byte is always the mandatory data byte taken from a local register, and the controller cannot refuse it. Further payload bytes then come from a transmit FIFO, in order, until the FIFO runs dry or the payload limit set by the controller is reached. Each byte carries a "more data" flag that the bus engine turns into the T-bit.

Software starts an interrupt with a request strobe. The request is refused when the target is not in I3C mode or when the controller has disabled interrupts for this target. The `busy` bit stays high until the interrupt is over. The outcome is kept in two sticky flags: a done flag for a clean finish, and an abort flag for an early end forced by the controller.

Both byte interfaces use valid/ready. A byte moves only on a cycle where valid and ready are both high. While `tx_ready` is low, the sequencer holds `tx_valid`, `tx_data` and `tx_more`. The FIFO is popped (`fifo_ready`) only on a cycle where a payload byte is accepted downstream.

Top module: `ibi_payload_seq`

## Requirements
- R1: A request strobe while idle is refused, so `busy` and `hdr_req` stay 0, if `i3c_mode` is 0 or `ibi_en` is 0.
- R2: An accepted request raises `busy` and `hdr_req` one cycle after the strobe. A header NACK returns the block to idle, clears `busy`, and leaves both flags unchanged.
- R3: After a header ACK, the next byte offered on `tx_data` is the mandatory byte. Its bit 7 is always 0, both on `tx_data` and on `mdb_rd`, whatever was written to that bit.
- R4: Controller end events (`ctl_eod`, `ctl_restart`, `ctl_stop`) while the mandatory byte is pending are ignored. The byte stays offered until it is accepted.
- R5: With `max_len` = 0 only the mandatory byte is sent. Its `tx_more` is 0 and the FIFO is not popped.
- R6: With a nonzero limit, payload bytes follow in FIFO order. `tx_more` is 1 when another byte will follow, and it is 0 on the byte that empties the FIFO.
- R7: No more than `max_len` payload bytes are sent. The byte that reaches the limit carries `tx_more` = 0, even if the FIFO still holds data.
- R8: An end event during the payload phase stops sending at once and sets `abort_flag`. `busy` clears on the next cycle, and no byte is popped in the cycle of the event.
- R9: After the last byte has been accepted, an end event sets `done_flag` and clears `busy`.
- R10: While `tx_ready` is low, the offered byte and its `tx_more` value stay stable.
- R11: `fifo_ready` is high only in a cycle where `tx_valid` and `tx_ready` are both high.
- R12: `done_flag` and `abort_flag` stay set until `flag_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | 1 | Software strobe that starts an interrupt |
| mdb_wr_en | input | 1 | Write strobe for the mandatory-byte register |
| mdb_wr_data | input | 8 | Value written to the mandatory-byte register |
| mdb_rd | output | 8 | Readback of the mandatory byte (bit 7 reads 0) |
| max_len | input | 8 | Stored payload limit in bytes, not counting the mandatory byte |
| i3c_mode | input | 1 | Target is in I3C mode |
| ibi_en | input | 1 | Controller allows interrupts from this target |
| hdr_req | output | 1 | Asks the bus engine to send the interrupt header |
| hdr_ack | input | 1 | Controller acknowledged the header |
| hdr_nack | input | 1 | Controller refused the header |
| fifo_valid | input | 1 | Transmit FIFO has a byte at its head |
| fifo_data | input | 8 | Transmit FIFO head byte |
| fifo_level | input | 5 | Number of bytes in the transmit FIFO |
| fifo_ready | output | 1 | Pops the FIFO head |
| tx_valid | output | 1 | Byte offered to the bus engine |
| tx_data | output | 8 | Offered byte |
| tx_more | output | 1 | 1 when another byte follows this one (T-bit) |
| tx_ready | input | 1 | Bus engine accepts the offered byte |
| ctl_eod | input | 1 | Controller ended the data at a T-bit |
| ctl_restart | input | 1 | Repeated START seen |
| ctl_stop | input | 1 | STOP seen |
| busy | output | 1 | Request bit; cleared by hardware at the end |
| done_flag | output | 1 | Sticky: interrupt finished cleanly |
| abort_flag | output | 1 | Sticky: controller cut the payload short |
| flag_clr | input | 1 | Clears both sticky flags |

## Verification
Every output is a state decode or a mux of the current inputs, so the stream outputs (`tx_valid`, `tx_data`, `tx_more`, `fifo_ready`) reflect a stimulus in the same cycle. `busy`, `hdr_req` and the two flags change one clock edge after the strobe, acknowledge or end event that causes them. The bench drives inputs just after the falling edge. It checks same-cycle results half a period later, before the next rising edge, and checks registered results at the falling edge after that rising edge. Each byte handshake takes exactly one rising edge, so the byte order and the `tx_more` value are compared byte by byte against a FIFO model kept in the bench.

// File: rtl/ibi_pkg.sv
package ibi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ACK,
    ST_SEND_MDB,
    ST_SEND_PAYLOAD,
    ST_WAIT_END
  } ibi_state_e;
endpackage

// File: rtl/ibi_mdb_reg.sv
module ibi_mdb_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] mdb_q
);
  logic [DW-2:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else if (wr_en) low_q <= wr_data[DW-2:0];
  end

  // Reserved top bit: never stored
  assign mdb_q = {1'b0, low_q};
endmodule

// File: rtl/ibi_len_ctr.sv
module ibi_len_ctr #(
  parameter int LW    = 8,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LW-1:0]    max_len,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             more_after_mdb,
  output logic             more_after_cur
);
  logic [LW-1:0] cnt_q;
  logic [LW:0]   cnt_next_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_next_w     = {1'b0, cnt_q} + 1'b1;
  assign more_after_mdb = (max_len != '0) && (fifo_level != '0);
  assign more_after_cur = (cnt_next_w < {1'b0, max_len}) && (fifo_level >= LVL_W'(2));

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> ({1'b0, cnt_q} < {1'b0, max_len})); // R7
endmodule

// File: rtl/ibi_payload_seq.sv
module ibi_payload_seq
  import ibi_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LW    = 8,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_set,
  input  logic             mdb_wr_en,
  input  logic [DW-1:0]    mdb_wr_data,
  output logic [DW-1:0]    mdb_rd,
  input  logic [LW-1:0]    max_len,
  input  logic             i3c_mode,
  input  logic             ibi_en,
  output logic             hdr_req,
  input  logic             hdr_ack,
  input  logic             hdr_nack,
  input  logic             fifo_valid,
  input  logic [DW-1:0]    fifo_data,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             fifo_ready,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_data,
  output logic             tx_more,
  input  logic             tx_ready,
  input  logic             ctl_eod,
  input  logic             ctl_restart,
  input  logic             ctl_stop,
  output logic             busy,
  output logic             done_flag,
  output logic             abort_flag,
  input  logic             flag_clr
);
  ibi_state_e state_q, state_d;
  logic [DW-1:0] mdb_q;
  logic end_evt, more_mdb, more_cur, pay_accept, done_set, abort_set;

  assign end_evt = ctl_eod | ctl_restart | ctl_stop;

  ibi_mdb_reg #(.DW(DW)) mdb_i (
    .clk(clk), .rst_n(rst_n), .wr_en(mdb_wr_en),
    .wr_data(mdb_wr_data), .mdb_q(mdb_q)
  );

  ibi_len_ctr #(.LW(LW), .LVL_W(LVL_W)) len_i (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q == ST_WAIT_ACK), .inc(pay_accept),
    .max_len(max_len), .fifo_level(fifo_level),
    .more_after_mdb(more_mdb), .more_after_cur(more_cur)
  );

  // Byte stream toward the bus engine
  always_comb begin
    tx_valid = 1'b0;
    tx_data  = '0;
    tx_more  = 1'b0;
    unique case (state_q)
      ST_SEND_MDB: begin
        tx_valid = 1'b1;
        tx_data  = mdb_q;
        tx_more  = more_mdb;
      end
      ST_SEND_PAYLOAD: begin
        tx_valid = fifo_valid & ~end_evt;
        tx_data  = fifo_data;
        tx_more  = more_cur;
      end
      default: ;
    endcase
  end

  assign pay_accept = (state_q == ST_SEND_PAYLOAD) && tx_valid && tx_ready;
  assign fifo_ready = pay_accept;

  // Sequencing
  always_comb begin
    state_d   = state_q;
    done_set  = 1'b0;
    abort_set = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (req_set && i3c_mode && ibi_en) state_d = ST_WAIT_ACK;
      ST_WAIT_ACK:
        if (hdr_nack) state_d = ST_IDLE;
        else if (hdr_ack) state_d = ST_SEND_MDB;
      ST_SEND_MDB:
        if (tx_ready) state_d = more_mdb ? ST_SEND_PAYLOAD : ST_WAIT_END;
      ST_SEND_PAYLOAD:
        if (end_evt) begin
          state_d   = ST_IDLE;
          abort_set = 1'b1;
        end else if (pay_accept) begin
          state_d = more_cur ? ST_SEND_PAYLOAD : ST_WAIT_END;
        end
      ST_WAIT_END:
        if (end_evt) begin
          state_d  = ST_IDLE;
          done_set = 1'b1;
        end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      done_flag  <= 1'b0;
      abort_flag <= 1'b0;
    end else begin
      state_q <= state_d;
      if (done_set) done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
      if (abort_set) abort_flag <= 1'b1;
      else if (flag_clr) abort_flag <= 1'b0;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign hdr_req = (state_q == ST_WAIT_ACK);
  assign mdb_rd  = mdb_q;

  AST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_set && !(i3c_mode && ibi_en)) |=> !busy); // R1
  AST_NACK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_req && hdr_nack && !flag_clr) |=> (!busy && $stable(done_flag) && $stable(abort_flag))); // R2
  AST_MDB_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND_MDB) |-> (tx_valid && !tx_data[DW-1])); // R3
  AST_MDB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND_MDB && !tx_ready) |=> (state_q == ST_SEND_MDB)); // R4
  AST_SIZE0: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND_MDB && max_len == '0) |-> !tx_more); // R5
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND_PAYLOAD && end_evt) |=> (!tx_valid && abort_flag)); // R8
  AST_POP_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (tx_valid && tx_ready)); // R11
endmodule

// File: tb/ibi_payload_seq_tb.sv
module ibi_payload_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_set = 0, mdb_wr_en = 0, i3c_mode = 1, ibi_en = 1;
  logic [7:0] mdb_wr_data = 0, max_len = 0, mdb_rd, tx_data;
  logic hdr_req, hdr_ack = 0, hdr_nack = 0;
  logic fifo_valid, fifo_ready, tx_valid, tx_more, tx_ready = 0;
  logic [7:0] fifo_data;
  logic [4:0] fifo_level;
  logic ctl_eod = 0, ctl_restart = 0, ctl_stop = 0;
  logic busy, done_flag, abort_flag, flag_clr = 0;

  int n_tests = 0, n_fail = 0;

  // Bench FIFO model: tail moved by the stimulus, head by pops
  logic [7:0] q [16];
  int head = 0, tail = 0;
  assign fifo_level = 5'(tail - head);
  assign fifo_valid = (tail != head);
  assign fifo_data  = q[head % 16];
  always @(posedge clk) if (fifo_ready) head <= head + 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibi_payload_seq dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    q[tail % 16] = b;
    tail++;
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic start_ibi();
    req_set = 1; step(); req_set = 0;
    chk(busy && hdr_req, "R2 start", {busy, hdr_req}, 3);
    hdr_ack = 1; step(); hdr_ack = 0;
  endtask

  // Accept one byte and compare it with the expected value
  task automatic take(input logic [7:0] d, input logic m, input string req);
    tx_ready = 1; #1;
    chk(tx_valid && tx_data == d, req, tx_data, d);
    chk(tx_more == m, {req, " more"}, tx_more, m);
    step(); tx_ready = 0; #1;
  endtask

  task automatic end_evt_stop();
    ctl_stop = 1; step(); ctl_stop = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !hdr_req && !tx_valid && !done_flag && !abort_flag && mdb_rd == 0,
        "R2 reset", {busy, hdr_req, tx_valid, done_flag, abort_flag}, 0);
  endtask

  task automatic t_refuse();
    i3c_mode = 0; req_set = 1; step(); req_set = 0;
    chk(!busy && !hdr_req, "R1 not i3c", busy, 0);
    i3c_mode = 1; ibi_en = 0; req_set = 1; step(); req_set = 0;
    chk(!busy && !hdr_req, "R1 disabled", busy, 0);
    ibi_en = 1;
  endtask

  task automatic t_nack();
    mdb_wr_en = 1; mdb_wr_data = 8'hFF; step(); mdb_wr_en = 0;
    chk(mdb_rd == 8'h7F, "R3 readback", mdb_rd, 8'h7F);
    req_set = 1; step(); req_set = 0;
    hdr_nack = 1; step(); hdr_nack = 0;
    chk(!busy && !done_flag && !abort_flag, "R2 nack", {busy, done_flag, abort_flag}, 0);
  endtask

  task automatic t_size0();
    max_len = 0; push(8'hA1); push(8'hA2);
    start_ibi();
    ctl_stop = 1; ctl_restart = 1; step(); ctl_stop = 0; ctl_restart = 0;
    chk(busy && tx_valid && !abort_flag, "R4 mdb survives", {busy, tx_valid}, 3);
    take(8'h7F, 1'b0, "R3 R5 mdb");
    chk(!tx_valid && busy && fifo_level == 2, "R5 no pop", fifo_level, 2);
    end_evt_stop();
    chk(done_flag && !busy && !abort_flag, "R9 done", {done_flag, busy}, 2);
    step(); step();
    chk(done_flag, "R12 sticky", done_flag, 1);
    flag_clr = 1; step(); flag_clr = 0;
    chk(!done_flag, "R12 clear", done_flag, 0);
  endtask

  task automatic t_drain();
    max_len = 10; push(8'hA3);
    mdb_wr_en = 1; mdb_wr_data = 8'h15; step(); mdb_wr_en = 0;
    start_ibi();
    take(8'h15, 1'b1, "R3 mdb");
    chk(tx_valid && tx_data == 8'hA1 && tx_more, "R10 hold a", tx_data, 8'hA1);
    step();
    chk(tx_valid && tx_data == 8'hA1 && tx_more && !fifo_ready, "R10 hold b", tx_data, 8'hA1);
    take(8'hA1, 1'b1, "R6 byte1");
    take(8'hA2, 1'b1, "R6 byte2");
    take(8'hA3, 1'b0, "R6 last");
    chk(!tx_valid && busy && fifo_level == 0, "R6 drained", fifo_level, 0);
    ctl_restart = 1; step(); ctl_restart = 0;
    chk(done_flag && !busy, "R9 restart end", done_flag, 1);
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic t_limit();
    max_len = 2; push(8'hB1); push(8'hB2); push(8'hB3); push(8'hB4);
    start_ibi();
    take(8'h15, 1'b1, "R7 mdb");
    take(8'hB1, 1'b1, "R7 first");
    take(8'hB2, 1'b0, "R7 at limit");
    chk(!tx_valid && fifo_level == 2, "R7 left in fifo", fifo_level, 2);
    end_evt_stop();
    chk(done_flag && !abort_flag, "R9 limit done", {done_flag, abort_flag}, 2);
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic t_abort();
    max_len = 10; push(8'hB5);
    start_ibi();
    take(8'h15, 1'b1, "R8 mdb");
    take(8'hB3, 1'b1, "R8 first");
    tx_ready = 1; ctl_eod = 1; #1;
    chk(!fifo_ready && !tx_valid, "R11 no pop on abort", fifo_ready, 0);
    step(); tx_ready = 0; ctl_eod = 0; #1;
    chk(abort_flag && !busy && !done_flag && !tx_valid, "R8 abort", {abort_flag, busy}, 2);
    chk(fifo_level == 2 && fifo_data == 8'hB4, "R8 head kept", fifo_data, 8'hB4);
    step(); step();
    chk(abort_flag, "R12 abort sticky", abort_flag, 1);
    flag_clr = 1; step(); flag_clr = 0;
    chk(!abort_flag, "R12 abort clear", abort_flag, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    t_reset();
    t_refuse();
    t_nack();
    t_size0();
    t_drain();
    t_limit();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule